// File: doc/BRIEF.md
# Fuse Array Register Interface

This block is the register-level face of a small one-time-programmable fuse array, shaped after what boot firmware expects to see. A 32-bit register bus with separate read and write strobes reaches fourteen plain control registers that hold the fuse macro's control settings: address, address I/O, address strobe, chip enable, clock, data-in, data strobe, program, test control, test mode, test repeat, test read, trim and write enable. Writes to these registers only store the value. No programming pulse, analog timing or repair logic is modelled.

One extra slot is read-only and returns fuse data. The fuse word picked by the address register comes back only while bit 0 of chip enable, data strobe and trim are all set. Otherwise the slot returns 0xFF. After reset every fuse word reads as all ones, except two adjacent words. One of these holds a serial-number parameter and the next holds its bitwise complement. Each access that is unmapped, misaligned or not a full word gets a one-cycle error response and changes nothing.

Top module: `otp_fuse_regif`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is applied and in the first cycle after it, `bus_rdata` is 0 and `bus_err` is 0. Every control register then reads 0, and the data-out slot reads 0xFF.
- R2: The fourteen read/write registers sit at byte offsets 0x00 address, 0x04 address I/O, 0x08 address strobe, 0x0C chip enable, 0x10 clock, 0x14 data-in, 0x1C data strobe, 0x20 program, 0x24 test control, 0x28 test mode, 0x2C test repeat, 0x30 test read, 0x34 trim and 0x38 write enable. A full-word write is returned unchanged by a later read. The address register is the exception covered by R3.
- R3: A write to the address register (0x00) keeps only its low log2(FUSE_WORDS) bits, which are bits 9:0 by default. All higher bits read back as 0.
- R4: A read of the data-out slot (0x18) returns the fuse word indexed by the address register when bit 0 is set in chip enable (0x0C), data strobe (0x1C) and trim (0x34).
- R5: A data-out read returns 0x000000FF whenever bit 0 is clear in any one of those three registers.
- R6: Fuse word SERIAL_ADDR (default 0xFC) holds SERIAL (default 0xA5C30F12). Word SERIAL_ADDR+1 holds ~SERIAL (0x5A3CF0ED). Every other word holds 0xFFFFFFFF.
- R7: A write to the data-out slot stores nothing, does not change what the slot returns, and raises no error.
- R8: An access to an offset at or above 0x3C, or with address bits 1:0 non-zero, sets `bus_err` in the next cycle. A read returns 0 and a write changes no register.
- R9: An access whose `bus_size` is not 2'b10 (full word; 2'b00 byte, 2'b01 halfword) sets `bus_err` in the next cycle, returns 0 and changes no register.
- R10: Read data and error are registered and valid exactly one cycle after the access. In a cycle after no access, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_err | output | 1 | Access error, one cycle after the access |

## Verification
A wrong stored value in a control register shows up at `bus_rdata` on the first read of that offset, one cycle after the strobe. A wrong enable bit shows up as a data-out read that returns fuse data where 0xFF was expected, or the reverse. A mask or fuse-content fault appears as a wrong data-out word on the cycle after a read at the serial address, at the word after it, or at the top address. Decode faults show one cycle after the access: `bus_err` is missing or spurious, or a rejected write shows up in a later read-back.

// File: rtl/otp_regif_pkg.sv
package otp_regif_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_SLOTS = 15;
    localparam logic [1:0]  SIZE_WORD = 2'b10;
    localparam logic [WORD_W-1:0] DOUT_CLOSED = 32'h0000_00FF;

    // Slot order fixes the byte offset (slot * 4).
    typedef enum logic [3:0] {
        SLOT_ADDR      = 4'd0,
        SLOT_ADDR_IO   = 4'd1,
        SLOT_ADDR_STB  = 4'd2,
        SLOT_CHIP_EN   = 4'd3,
        SLOT_CLOCK     = 4'd4,
        SLOT_DIN       = 4'd5,
        SLOT_DOUT      = 4'd6,
        SLOT_DSTB      = 4'd7,
        SLOT_PROG      = 4'd8,
        SLOT_TEST_CTL  = 4'd9,
        SLOT_TEST_MODE = 4'd10,
        SLOT_TEST_REP  = 4'd11,
        SLOT_TEST_READ = 4'd12,
        SLOT_TRIM      = 4'd13,
        SLOT_WR_EN     = 4'd14
    } slot_e;

    typedef struct packed {
        logic  mapped;
        logic  size_ok;
        slot_e slot;
    } decode_t;

    function automatic logic gate_open(input logic ce, input logic ds, input logic tr);
        return ce & ds & tr;
    endfunction

endpackage

// File: rtl/otp_regif_decode.sv
module otp_regif_decode
    import otp_regif_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output decode_t           dec
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;

    assign word_idx    = addr[ADDR_W-1:2];
    assign dec.mapped  = (addr[1:0] == 2'b00) && (word_idx < IDX_W'(NUM_SLOTS));
    assign dec.size_ok = (size == SIZE_WORD);
    assign dec.slot    = slot_e'(word_idx[3:0]);
endmodule

// File: rtl/otp_regif_ctrl_bank.sv
module otp_regif_ctrl_bank
    import otp_regif_pkg::*;
#(
    parameter int unsigned FUSE_AW = 10
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_stb,
    input  slot_e                             wr_slot,
    input  logic [WORD_W-1:0]                 wdata,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]  regs
);
    localparam int unsigned PAD_W = WORD_W - FUSE_AW;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g == int'(SLOT_DOUT)) begin : g_ro
            // Data-out has no storage; its read value comes from the fuse path.
            assign regs[g] = '0;
        end else if (g == int'(SLOT_ADDR)) begin : g_masked
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (wr_stb && (wr_slot == slot_e'(g)))
                    regs[g] <= {{PAD_W{1'b0}}, wdata[FUSE_AW-1:0]};
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (wr_stb && (wr_slot == slot_e'(g)))
                    regs[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/otp_regif_fuse_rom.sv
module otp_regif_fuse_rom
    import otp_regif_pkg::*;
#(
    parameter int unsigned       FUSE_AW     = 10,
    parameter int unsigned       SERIAL_ADDR = 252,
    parameter logic [WORD_W-1:0] SERIAL      = 32'hA5C3_0F12
) (
    input  logic [FUSE_AW-1:0] idx,
    output logic [WORD_W-1:0]  word
);
    localparam logic [FUSE_AW-1:0] SER_LO = FUSE_AW'(SERIAL_ADDR);
    localparam logic [FUSE_AW-1:0] SER_HI = FUSE_AW'(SERIAL_ADDR + 1);

    // Fuse contents never change after reset, so they are computed, not stored.
    always_comb begin
        if (idx == SER_LO)
            word = SERIAL;
        else if (idx == SER_HI)
            word = ~SERIAL;
        else
            word = '1;
    end
endmodule

// File: rtl/otp_fuse_regif.sv
module otp_fuse_regif
    import otp_regif_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       FUSE_WORDS  = 1024,
    parameter int unsigned       SERIAL_ADDR = 252,
    parameter logic [WORD_W-1:0] SERIAL      = 32'hA5C3_0F12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              bus_err
);
    localparam int unsigned FUSE_AW = $clog2(FUSE_WORDS);

    decode_t                            dec;
    logic                               access_ok;
    logic [NUM_SLOTS-1:0][WORD_W-1:0]   ctrl_regs;
    logic [WORD_W-1:0]                  fuse_word;
    logic [WORD_W-1:0]                  rd_word;
    logic                               gate_ce, gate_ds, gate_tr;

    otp_regif_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .size (bus_size),
        .dec  (dec)
    );

    assign access_ok = dec.mapped && dec.size_ok;

    otp_regif_ctrl_bank #(.FUSE_AW(FUSE_AW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (bus_wr && access_ok),
        .wr_slot (dec.slot),
        .wdata   (bus_wdata),
        .regs    (ctrl_regs)
    );

    otp_regif_fuse_rom #(
        .FUSE_AW     (FUSE_AW),
        .SERIAL_ADDR (SERIAL_ADDR),
        .SERIAL      (SERIAL)
    ) u_rom (
        .idx  (ctrl_regs[SLOT_ADDR][FUSE_AW-1:0]),
        .word (fuse_word)
    );

    assign gate_ce = ctrl_regs[SLOT_CHIP_EN][0];
    assign gate_ds = ctrl_regs[SLOT_DSTB][0];
    assign gate_tr = ctrl_regs[SLOT_TRIM][0];

    always_comb begin
        if (dec.slot == SLOT_DOUT)
            rd_word = gate_open(gate_ce, gate_ds, gate_tr) ? fuse_word : DOUT_CLOSED;
        else
            rd_word = ctrl_regs[dec.slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_rd && access_ok) ? rd_word : '0;
            bus_err   <= (bus_rd || bus_wr) && !access_ok;
        end
    end
endmodule

// File: rtl/otp_fuse_regif_checks.sv
module otp_fuse_regif_checks #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              gate_ce,
    input logic              gate_ds,
    input logic              gate_tr
);
    localparam logic [ADDR_W-1:0] FIRST_FREE = ADDR_W'(60);
    localparam logic [ADDR_W-1:0] DOUT_OFS   = ADDR_W'(24);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bus_rdata == 32'd0 && !bus_err));

    assert_closed_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size == 2'b10 && bus_addr == DOUT_OFS && !(gate_ce && gate_ds && gate_tr))
        |=> (bus_rdata == 32'h0000_00FF && !bus_err));

    assert_unmapped_err_R8: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_addr >= FIRST_FREE) |=> (bus_err && bus_rdata == 32'd0));

    assert_bad_size_err_R9: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_size != 2'b10) |=> (bus_err && bus_rdata == 32'd0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> (bus_rdata == 32'd0 && !bus_err));
endmodule

bind otp_fuse_regif otp_fuse_regif_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .gate_ce   (gate_ce),
    .gate_ds   (gate_ds),
    .gate_tr   (gate_tr)
);

// File: tb/otp_fuse_regif_test.sv
module otp_fuse_regif_test;

    localparam logic [31:0] SER     = 32'hA5C3_0F12;
    localparam logic [31:0] SER_INV = 32'h5A3C_F0ED;
    localparam int          NVEC    = 26;

    // {wr, addr, size, wdata, expected rdata, expected err, requirement}
    localparam logic [79:0] VECS [0:NVEC-1] = '{
        {1'b0, 8'h18, 2'd2, 32'h0,        32'h0000_00FF, 1'b0, 4'd5},  // R5 all gates closed
        {1'b1, 8'h0C, 2'd2, 32'h1,        32'h0,         1'b0, 4'd2},
        {1'b1, 8'h1C, 2'd2, 32'h1,        32'h0,         1'b0, 4'd2},
        {1'b0, 8'h18, 2'd2, 32'h0,        32'h0000_00FF, 1'b0, 4'd5},  // R5 trim clear
        {1'b1, 8'h34, 2'd2, 32'h1,        32'h0,         1'b0, 4'd2},
        {1'b0, 8'h18, 2'd2, 32'h0,        32'hFFFF_FFFF, 1'b0, 4'd4},  // R4 word 0
        {1'b1, 8'h00, 2'd2, 32'hFC,       32'h0,         1'b0, 4'd3},
        {1'b0, 8'h18, 2'd2, 32'h0,        SER,           1'b0, 4'd6},  // R6 serial
        {1'b1, 8'h00, 2'd2, 32'hFFFF_F0FD,32'h0,         1'b0, 4'd3},
        {1'b0, 8'h00, 2'd2, 32'h0,        32'h0000_00FD, 1'b0, 4'd3},  // R3 mask
        {1'b0, 8'h18, 2'd2, 32'h0,        SER_INV,       1'b0, 4'd6},  // R6 complement
        {1'b1, 8'h18, 2'd2, 32'h1234_5678,32'h0,         1'b0, 4'd7},  // R7 no error
        {1'b0, 8'h18, 2'd2, 32'h0,        SER_INV,       1'b0, 4'd7},  // R7 unchanged
        {1'b1, 8'h0C, 2'd2, 32'hFFFF_FFFE,32'h0,         1'b0, 4'd5},
        {1'b0, 8'h18, 2'd2, 32'h0,        32'h0000_00FF, 1'b0, 4'd5},  // R5 chip enable bit 0 clear
        {1'b1, 8'h3C, 2'd2, 32'h55,       32'h0,         1'b1, 4'd8},  // R8
        {1'b0, 8'h3C, 2'd2, 32'h0,        32'h0,         1'b1, 4'd8},
        {1'b0, 8'h02, 2'd2, 32'h0,        32'h0,         1'b1, 4'd8},  // R8 misaligned
        {1'b1, 8'h20, 2'd1, 32'hDEAD,     32'h0,         1'b1, 4'd9},  // R9 halfword write
        {1'b0, 8'h20, 2'd2, 32'h0,        32'h0,         1'b0, 4'd9},  // R9 nothing stored
        {1'b0, 8'h20, 2'd0, 32'h0,        32'h0,         1'b1, 4'd9},  // R9 byte read
        {1'b1, 8'h0C, 2'd2, 32'h1,        32'h0,         1'b0, 4'd2},
        {1'b0, 8'h18, 2'd2, 32'h0,        SER_INV,       1'b0, 4'd4},  // R4 gates open again
        {1'b1, 8'h00, 2'd2, 32'h3FF,      32'h0,         1'b0, 4'd3},
        {1'b0, 8'h18, 2'd2, 32'h0,        32'hFFFF_FFFF, 1'b0, 4'd4},  // R4 top word
        {1'b1, 8'hFC, 2'd2, 32'h77,       32'h0,         1'b1, 4'd8}   // R8 far offset
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    otp_fuse_regif uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_errors = n_errors + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One access: drive at a falling edge, sample registered result at the next one.
    task automatic access(input logic wr, input logic [7:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp,
                          input logic experr, input string tag);
        @(negedge clk);
        bus_wr    = wr;
        bus_rd    = !wr;
        bus_addr  = addr;
        bus_size  = sz;
        bus_wdata = wd;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        check($sformatf("%s rdata @%h", tag, addr), bus_rdata, exp);
        check($sformatf("%s err @%h", tag, addr), {31'd0, bus_err}, {31'd0, experr});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 32'd0);
        rst = 1'b0;
        check("R1 err after reset", {31'd0, bus_err}, 32'd0);

        // R1: all slots after reset
        for (int i = 0; i < 15; i++) begin
            access(1'b0, 8'(i * 4), 2'd2, 32'd0, (i == 6) ? 32'hFF : 32'd0, 1'b0, "R1");
        end

        for (int v = 0; v < NVEC; v++) begin
            logic [79:0] e;
            e = VECS[v];
            access(e[79], e[78:71], e[70:69], e[68:37], e[36:5], e[4],
                   $sformatf("R%0d vec%0d", e[3:0], v));
        end

        // R10: an idle cycle after a read returns zero
        access(1'b0, 8'h34, 2'd2, 32'd0, 32'd1, 1'b0, "R10 read");
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'd0);
        check("R10 idle err", {31'd0, bus_err}, 32'd0);

        // R2: write-read every read/write slot
        for (int i = 0; i < 15; i++) begin
            logic [31:0] pat;
            if (i == 6) continue;
            pat = 32'h8000_0001 ^ (32'(i) * 32'h0101_0101) ^ 32'h0F0F_0000;
            access(1'b1, 8'(i * 4), 2'd2, pat, 32'd0, 1'b0, "R2 write");
            access(1'b0, 8'(i * 4), 2'd2, 32'd0, (i == 0) ? (pat & 32'h3FF) : pat, 1'b0,
                   (i == 0) ? "R3 readback" : "R2 readback");
        end

        // R1: second reset clears stored values
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(1'b0, 8'h24, 2'd2, 32'd0, 32'd0, 1'b0, "R1 re-reset");
        access(1'b0, 8'h00, 2'd2, 32'd0, 32'd0, 1'b0, "R1 re-reset");
        access(1'b0, 8'h18, 2'd2, 32'd0, 32'hFF, 1'b0, "R1 re-reset");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule